// File: doc/BRIEF.md
# Converter Tile Power-Up Sequencer

This block brings one data-converter tile from reset to a usable state. A 4-bit step register advances through sixteen numbered steps, and each step belongs to one of six phases: configuration with a supply wait, supply adjustment, clock bring-up, calibration, stream-reset wait and done. Some steps wait on a cycle timer or on an input flag. The others last one clock. The analog side only sees the level outputs this block drives.

Two straps set the path through the steps. One selects an ADC or a DAC tile, and the other says whether the tile's PLL is in use. On a DAC tile the calibration steps pass straight through. With the PLL disabled, the lock wait is skipped. A start request begins the sequence, and a later request restarts it from step 0. Losing the input clock or the PLL lock after the clocks have been released also sends the tile back to step 0. The sequence then runs again by itself.

The supply wait and the calibration time are counts of clock cycles. Separate hardware and simulation values are kept as parameters, and a mode parameter picks between them.

Top module: `tile_pwrup_seq`

## Requirements
- R1: After reset the step is 0, the phase is 0 and every level output is low. The step stays at 0 until the first start request.
- R2: Steps are taken in ascending order, at most one per clock. The phase is 0 for steps 0-2, 1 for steps 3-5, 2 for steps 6-10, 3 for steps 11-13, 4 for step 14 and 5 for step 15. Every step that has no wait condition lasts exactly one cycle.
- R3: Step 1 lasts SUP_WAIT+1 cycles when the supply-good input is high. While supply-good is low the step stays at 1, and it leaves on the first clock edge where both conditions hold.
- R4: The analog-enable output is high at step 4 and above. The common-mode buffer enable is high at step 5 and above, and only on an ADC tile.
- R5: Step 6 holds until the clock-present input is high. With the PLL enabled, step 8 holds until PLL lock is high. With the PLL disabled, step 8 lasts one cycle and the lock input has no effect anywhere.
- R6: The clock-release output is high at step 10 and above.
- R7: On an ADC tile, step 12 lasts CAL_WAIT+1 cycles and the calibration output is high for exactly those cycles. On a DAC tile, step 12 lasts one cycle and the calibration output never rises.
- R8: Step 14 holds while the stream reset input (active low) is low. The step moves to 15 at the first clock edge after that reset is released.
- R9: The ready output is high exactly when the step is 15.
- R10: A start request at any step sets the step to 0 on the next edge and clears ready. The sequence then runs to step 15 again with no further request.
- R11: At step 10 or above, losing the clock-present input moves the step to 0 on the next edge and clears ready. So does losing PLL lock while the PLL is enabled. The sequence then restarts and waits at step 6 for the clock to return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_req | input | 1 | Start or restart request |
| supply_ok | input | 1 | External supplies good |
| clk_ok | input | 1 | Good input clock detected |
| pll_en | input | 1 | Strap: tile PLL in use |
| pll_lock | input | 1 | PLL locked |
| is_adc | input | 1 | Strap: 1 = ADC tile, 0 = DAC tile |
| strm_rst_n | input | 1 | Streaming-interface reset, active low |
| step | output | 4 | Current step number 0-15 |
| phase | output | 3 | Current phase 0-5 |
| ana_en | output | 1 | Regulators and bias enabled |
| cm_buf_en | output | 1 | Common-mode output buffer enabled |
| clk_release | output | 1 | Clocks released to the digital section |
| cal_run | output | 1 | Calibration in progress |
| ready | output | 1 | Power-up complete |

## Verification
Every output is decoded combinationally from the step register. Each output is therefore due in the same cycle as the step, one clock edge after the input that caused the transition. The bench samples on the falling edge and records how many samples each step lasts. It compares those counts with values computed from SUP_WAIT, CAL_WAIT and the number of samples it chose to hold each gating input low. An input is released on the sample where its chosen count is reached, so the step moves on at the very next rising edge. For restarts and faults the bench applies the stimulus on one falling edge and expects step 0 on the next.

// File: rtl/tile_pwrup_pkg.sv
`timescale 1ns/1ps
package tile_pwrup_pkg;

  localparam int STEP_W = 4;

  localparam logic [3:0] ST_CFG_LOAD  = 4'd0;
  localparam logic [3:0] ST_SUP_WAIT  = 4'd1;
  localparam logic [3:0] ST_REG_EN    = 4'd4;
  localparam logic [3:0] ST_CMB_EN    = 4'd5;
  localparam logic [3:0] ST_CLK_DET   = 4'd6;
  localparam logic [3:0] ST_PLL_WAIT  = 4'd8;
  localparam logic [3:0] ST_CLK_REL   = 4'd10;
  localparam logic [3:0] ST_CAL_RUN   = 4'd12;
  localparam logic [3:0] ST_STRM_WAIT = 4'd14;
  localparam logic [3:0] ST_DONE      = 4'd15;

  typedef enum logic [2:0] {
    PH_CONFIG     = 3'd0,
    PH_SUPPLY_ADJ = 3'd1,
    PH_CLOCK      = 3'd2,
    PH_CALIB      = 3'd3,
    PH_STREAM     = 3'd4,
    PH_DONE       = 3'd5
  } phase_e;

  // Uneven mapping of the sixteen steps onto six phases.
  function automatic phase_e phase_of(input logic [3:0] s);
    if (s <= 4'd2)       return PH_CONFIG;
    else if (s <= 4'd5)  return PH_SUPPLY_ADJ;
    else if (s <= 4'd10) return PH_CLOCK;
    else if (s <= 4'd13) return PH_CALIB;
    else if (s == 4'd14) return PH_STREAM;
    else                 return PH_DONE;
  endfunction

  // Condition under which the current step may advance.
  function automatic logic step_gate(
    input logic [3:0] s,
    input logic go, input logic supply_ok, input logic clk_ok,
    input logic pll_en, input logic pll_lock, input logic is_adc,
    input logic strm_rst_n, input logic tmr_zero);
    case (s)
      ST_CFG_LOAD:  return go;
      ST_SUP_WAIT:  return tmr_zero & supply_ok;
      ST_CLK_DET:   return clk_ok;
      ST_PLL_WAIT:  return ~pll_en | pll_lock;
      ST_CAL_RUN:   return ~is_adc | tmr_zero;
      ST_STRM_WAIT: return strm_rst_n;
      ST_DONE:      return 1'b0;
      default:      return 1'b1;
    endcase
  endfunction

  // Preset for the wait timer on entry to a timed step.
  function automatic int unsigned wait_preset(input logic [3:0] s,
                                              input int unsigned sup_w,
                                              input int unsigned cal_w);
    return (s == ST_SUP_WAIT) ? sup_w : cal_w;
  endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
`timescale 1ns/1ps
module pwr_wait_timer #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             zero
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwr_step_next.sv
`timescale 1ns/1ps
module pwr_step_next #(
  parameter int STEP_W = 4
) (
  input  logic [STEP_W-1:0] step,
  input  logic              gate,
  input  logic              start_req,
  input  logic              fault,
  output logic [STEP_W-1:0] nxt,
  output logic              adv
);
  localparam logic [STEP_W-1:0] LAST = {STEP_W{1'b1}};

  always_comb begin
    adv = 1'b0;
    nxt = step;
    if (start_req || fault) begin
      nxt = '0;
    end else if (gate && step != LAST) begin
      adv = 1'b1;
      nxt = step + 1'b1;
    end
  end
endmodule

// File: rtl/pwr_out_decode.sv
`timescale 1ns/1ps
module pwr_out_decode
  import tile_pwrup_pkg::*;
(
  input  logic [3:0] step,
  input  logic       is_adc,
  output logic [2:0] phase,
  output logic       ana_en,
  output logic       cm_buf_en,
  output logic       clk_release,
  output logic       cal_run,
  output logic       ready
);
  always_comb begin
    phase       = phase_of(step);
    ana_en      = (step >= ST_REG_EN);
    cm_buf_en   = is_adc && (step >= ST_CMB_EN);
    clk_release = (step >= ST_CLK_REL);
    cal_run     = is_adc && (step == ST_CAL_RUN);
    ready       = (step == ST_DONE);
  end
endmodule

// File: rtl/tile_pwrup_seq.sv
`timescale 1ns/1ps
module tile_pwrup_seq
  import tile_pwrup_pkg::*;
#(
  parameter bit          SIM_MODE     = 1'b1,
  parameter int unsigned SUP_WAIT_HW  = 5_000_000,
  parameter int unsigned SUP_WAIT_SIM = 40_000,
  parameter int unsigned CAL_WAIT_HW  = 2_000_000,
  parameter int unsigned CAL_WAIT_SIM = 12_000,
  parameter int          CNT_W        = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_req,
  input  logic       supply_ok,
  input  logic       clk_ok,
  input  logic       pll_en,
  input  logic       pll_lock,
  input  logic       is_adc,
  input  logic       strm_rst_n,
  output logic [3:0] step,
  output logic [2:0] phase,
  output logic       ana_en,
  output logic       cm_buf_en,
  output logic       clk_release,
  output logic       cal_run,
  output logic       ready
);
  localparam int unsigned SUP_WAIT = SIM_MODE ? SUP_WAIT_SIM : SUP_WAIT_HW;
  localparam int unsigned CAL_WAIT = SIM_MODE ? CAL_WAIT_SIM : CAL_WAIT_HW;

  logic [STEP_W-1:0] step_q, step_nxt;
  logic              go_q;
  logic              gate_w, adv_w, fault_w, tmr_zero, tmr_load;
  logic [CNT_W-1:0]  tmr_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= '0;
      go_q   <= 1'b0;
    end else begin
      step_q <= step_nxt;
      if (start_req) go_q <= 1'b1;
    end
  end

  assign gate_w  = step_gate(step_q, go_q, supply_ok, clk_ok, pll_en,
                             pll_lock, is_adc, strm_rst_n, tmr_zero);
  assign fault_w = clk_release && (!clk_ok || (pll_en && !pll_lock));

  assign tmr_load = (step_nxt != step_q) &&
                    (step_nxt == ST_SUP_WAIT || step_nxt == ST_CAL_RUN);
  assign tmr_val  = CNT_W'(wait_preset(step_nxt, SUP_WAIT, CAL_WAIT));

  pwr_step_next #(.STEP_W(STEP_W)) u_next (
    .step(step_q), .gate(gate_w), .start_req(start_req), .fault(fault_w),
    .nxt(step_nxt), .adv(adv_w)
  );

  pwr_wait_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .zero(tmr_zero)
  );

  pwr_out_decode u_dec (
    .step(step_q), .is_adc(is_adc), .phase(phase), .ana_en(ana_en),
    .cm_buf_en(cm_buf_en), .clk_release(clk_release), .cal_run(cal_run),
    .ready(ready)
  );

  assign step = step_q;
endmodule

// File: rtl/tile_pwrup_seq_chk.sv
`timescale 1ns/1ps
module tile_pwrup_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_req,
  input logic       supply_ok,
  input logic       clk_ok,
  input logic       pll_en,
  input logic       is_adc,
  input logic       strm_rst_n,
  input logic [3:0] step,
  input logic       cm_buf_en,
  input logic       clk_release,
  input logic       cal_run,
  input logic       ready,
  input logic       fault_w,
  input logic       adv_w
);
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_req && !fault_w) |=> (step == $past(step) || step == $past(step) + 4'd1)); // R2
  AST_ADV_PLUS1: assert property (@(posedge clk) disable iff (!rst_n)
    adv_w |=> step == $past(step) + 4'd1); // R2
  AST_SUP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd1 && !supply_ok && !start_req) |=> step == 4'd1); // R3
  AST_CMB_ADC_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    cm_buf_en |-> is_adc); // R4
  AST_PLL_SKIP: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd8 && !pll_en && !start_req) |=> step == 4'd9); // R5
  AST_DAC_NO_CAL: assert property (@(posedge clk) disable iff (!rst_n)
    !is_adc |-> !cal_run); // R7
  AST_STRM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd14 && !strm_rst_n && !start_req && !fault_w) |=> step == 4'd14); // R8
  AST_READY_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> step == 4'd15); // R9
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    start_req |=> (step == 4'd0 && !ready)); // R10
  AST_CLK_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_release && !clk_ok) |=> (step == 4'd0 && !ready)); // R11
endmodule

bind tile_pwrup_seq tile_pwrup_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_req(start_req), .supply_ok(supply_ok),
  .clk_ok(clk_ok), .pll_en(pll_en), .is_adc(is_adc), .strm_rst_n(strm_rst_n),
  .step(step), .cm_buf_en(cm_buf_en), .clk_release(clk_release),
  .cal_run(cal_run), .ready(ready), .fault_w(fault_w), .adv_w(adv_w)
);

// File: tb/tile_pwrup_seq_bench.sv
`timescale 1ns/1ps
module tile_pwrup_seq_bench;
  localparam int SUP = 6;
  localparam int CAL = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_req = 1'b0, supply_ok = 1'b0, clk_ok = 1'b0, pll_en = 1'b0;
  logic pll_lock = 1'b0, is_adc = 1'b0, strm_rst_n = 1'b0;
  logic [3:0] step;
  logic [2:0] phase;
  logic ana_en, cm_buf_en, clk_release, cal_run, ready;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  tile_pwrup_seq #(.SIM_MODE(1'b1), .SUP_WAIT_SIM(SUP), .CAL_WAIT_SIM(CAL))
  u_tile_pwrup_seq (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .supply_ok(supply_ok),
    .clk_ok(clk_ok), .pll_en(pll_en), .pll_lock(pll_lock), .is_adc(is_adc),
    .strm_rst_n(strm_rst_n), .step(step), .phase(phase), .ana_en(ana_en),
    .cm_buf_en(cm_buf_en), .clk_release(clk_release), .cal_run(cal_run),
    .ready(ready)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_phase(input int s);
    if (s < 3) return 0;
    if (s < 6) return 1;
    if (s < 11) return 2;
    if (s < 14) return 3;
    if (s == 14) return 4;
    return 5;
  endfunction

  task automatic wait_ready(input string req);
    int got = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (ready) begin got = 1; break; end
    end
    chk(req, "reached ready again", got, 1);
  endtask

  task automatic run_case(input bit adc, input bit pll, input int sup_d,
                          input int clk_d, input int lock_d, input int rst_d);
    int dw[16];
    int prev = 0;
    int cal_n = 0;
    int exp_dw;
    string req;
    foreach (dw[i]) dw[i] = 0;
    rst_n = 1'b0; start_req = 1'b0;
    is_adc = adc; pll_en = pll;
    supply_ok = (sup_d == 0); clk_ok = (clk_d == 0);
    pll_lock = (lock_d == 0); strm_rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "step after reset", int'(step), 0);
    chk("R1", "phase after reset", int'(phase), 0);
    chk("R1", "outputs after reset",
        int'({ana_en, cm_buf_en, clk_release, cal_run, ready}), 0);
    repeat (5) @(negedge clk);
    chk("R1", "idle without start", int'(step), 0);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    for (int g = 0; g < 3000; g++) begin
      int s;
      if (g > 0) @(negedge clk);
      s = int'(step);
      dw[s]++;
      if (cal_run) cal_n++;
      if (s != prev) chk("R2", "step order", s, prev + 1);
      prev = s;
      chk("R2", "phase map", int'(phase), exp_phase(s));
      chk("R4", "ana_en", int'(ana_en), int'(s >= 4));
      chk("R4", "cm_buf_en", int'(cm_buf_en), int'(adc && s >= 5));
      chk("R6", "clk_release", int'(clk_release), int'(s >= 10));
      chk("R9", "ready", int'(ready), int'(s == 15));
      if (s == 1 && sup_d > 0 && dw[1] == sup_d) supply_ok = 1'b1;
      if (s == 6 && clk_d > 0 && dw[6] == clk_d) clk_ok = 1'b1;
      if (s == 8 && pll && lock_d > 0 && dw[8] == lock_d) pll_lock = 1'b1;
      if (s == 14 && dw[14] == rst_d) strm_rst_n = 1'b1;
      if (s == 15) break;
    end
    for (int k = 0; k < 16; k++) begin
      exp_dw = 1; req = "R2";
      if (k == 1) begin req = "R3"; exp_dw = (sup_d > 0) ? sup_d : SUP + 1; end
      if (k == 6) begin req = "R5"; exp_dw = (clk_d > 0) ? clk_d : 1; end
      if (k == 8) begin req = "R5"; exp_dw = (pll && lock_d > 0) ? lock_d : 1; end
      if (k == 12) begin req = "R7"; exp_dw = adc ? CAL + 1 : 1; end
      if (k == 14) begin req = "R8"; exp_dw = rst_d; end
      chk(req, $sformatf("dwell at step %0d", k), dw[k], exp_dw);
    end
    chk("R7", "calibration cycles", cal_n, adc ? CAL + 1 : 0);
  endtask

  initial begin
    // ADC with PLL, then restart and clock-loss handling
    run_case(1'b1, 1'b1, 0, 0, 0, 3);
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
    chk("R10", "step after restart", int'(step), 0);
    chk("R10", "ready after restart", int'(ready), 0);
    wait_ready("R10");
    clk_ok = 1'b0;
    @(negedge clk);
    chk("R11", "step after clock loss", int'(step), 0);
    chk("R11", "ready after clock loss", int'(ready), 0);
    repeat (30) @(negedge clk);
    chk("R11", "waits for clock at step 6", int'(step), 6);
    clk_ok = 1'b1;
    wait_ready("R11");

    // ADC without PLL; lock stays low throughout
    run_case(1'b1, 1'b0, 10, 4, 5, 6);
    repeat (5) @(negedge clk);
    chk("R5", "lock ignored without PLL", int'(ready), 1);

    // DAC with PLL, then lock loss
    run_case(1'b0, 1'b1, 0, 0, 6, 2);
    pll_lock = 1'b0;
    @(negedge clk);
    chk("R11", "step after lock loss", int'(step), 0);
    chk("R11", "ready after lock loss", int'(ready), 0);

    // DAC without PLL
    run_case(1'b0, 1'b0, 12, 3, 0, 8);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R2 watchdog: actual step %0d expected run to finish", step);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule